// File: doc/BRIEF.md
# SPI Slave Error Flag Unit

This block watches the receive side of an SPI slave and reports two error conditions through one status register on a simple register bus. The first condition is a mode fault: the slave select line is released while a frame is still partly received. The second is an overrun: a frame finishes when the downstream receive buffer cannot take a whole word of the configured length. The serial clock, select and data lines are synchronised into the system clock domain. The serial clock's rising edges are counted per frame. A small shift path delivers each completed word, so the block knows exactly when a frame ends.

Each flag is sticky. Software clears a flag in two steps. It first reads the status register while the flag is set, and it then writes a 0 to that flag's bit. An error that arrives between the read and the write cancels the pending clear, so that error is not lost. A single output is the OR of the two flags and can serve as an interrupt request. The serial lines should toggle no faster than once every three system clocks.

Top module: `spi_err_status`

## Requirements
- R1: After a synchronous reset, both flags are 0, `bus_rdata` is 0, `err_irq` is 0 and `rx_valid` is 0.
- R2: A read of address `STAT_ADDR` returns, on the next cycle, the mode-fault flag in bit 2 and the overrun flag in bit 0. Bit 1 and bits above 2 always read 0, and `bus_rdata` is 0 on cycles that follow no status read.
- R3: In slave mode with the mode-fault enable set, the mode-fault flag is set when select turns inactive after at least one and fewer than the frame length of sampled serial clock rising edges.
- R4: No mode fault is raised when the enable is 0, or when select turns inactive on a frame boundary (the edge count of the current frame is 0).
- R5: Select is active high when `cfg_sel_high` is 1 and active low when it is 0. While select is inactive, clock edges are not counted and no word is delivered.
- R6: When a frame completes, the overrun flag is set if `rx_room` is less than the effective frame length. Equal or greater room sets nothing.
- R7: The effective frame length is `cfg_frame_len` clamped to the range 8..32. When a frame completes, `rx_valid` pulses for one cycle and `rx_word` holds the last frame's bits with the first bit received as the MSB, right-aligned and zero-extended.
- R8: A flag is cleared by a write of 0 to its bit only when a status read returned that flag as 1 after the last setting event. A write of 0 without such a read leaves the flag at 1.
- R9: Writing 1 to a flag bit, or any value to a reserved bit, changes no flag.
- R10: When `cfg_slave` is 0, neither flag is set, no edges are counted and `rx_valid` stays 0.
- R11: A setting event that occurs after the arming read and before the clearing write cancels the clear, and that flag stays 1.
- R12: When a setting event and a valid clearing write fall in the same cycle, the flag ends at 1.
- R13: `err_irq` equals the OR of the two flags, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_slave | input | 1 | 1 selects slave mode; 0 disables all detection |
| cfg_mf_en | input | 1 | Enables mode-fault detection |
| cfg_sel_high | input | 1 | Select active level: 1 high, 0 low |
| cfg_frame_len | input | LEN_W | Requested frame length in bits (clamped to 8..32) |
| rx_room | input | LEN_W | Free bits in the downstream receive buffer |
| spi_sck | input | 1 | Serial clock, asynchronous; data sampled on rising edges |
| spi_sel | input | 1 | Slave select, asynchronous |
| spi_mosi | input | 1 | Serial data in, asynchronous |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| err_irq | output | 1 | OR of both flags, registered |
| rx_valid | output | 1 | One-cycle pulse per completed frame |
| rx_word | output | MAX_LEN | Last completed word |

## Verification
The arming state is not visible at the ports. A wrong armed bit shows only as a flag that survives, or wrongly disappears after, the next write of 0. That error becomes visible in the read data one cycle after the following status read. A wrong edge count shifts the `rx_valid` pulse by at least two system cycles, and it makes a mode fault appear or vanish at the next select release. A wrongly set or cleared flag reaches `err_irq` within one cycle, even when no read takes place. For these reasons, the bench compares every output against a behavioural model on every clock, so that faults hidden in the state are caught at the first port where they appear.

// File: rtl/spi_err_pkg.sv
package spi_err_pkg;
  // Status register bit positions (software decodes these)
  localparam int MF_BIT = 2;
  localparam int OV_BIT = 0;
  // Flag vector indices inside the block
  localparam int MF_IDX = 1;
  localparam int OV_IDX = 0;
  localparam int NFLAG  = 2;
endpackage

// File: rtl/spi_err_sync.sv
module spi_err_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_err_frame.sv
module spi_err_frame #(
  parameter int MIN_LEN = 8,
  parameter int MAX_LEN = 32,
  parameter int LEN_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               slave,
  input  logic               mf_en,
  input  logic               sel_high,
  input  logic [LEN_W-1:0]   frame_len,
  input  logic [LEN_W-1:0]   rx_room,
  input  logic               sck_s,
  input  logic               sel_s,
  input  logic               mosi_s,
  output logic               mf_ev,
  output logic               ov_ev,
  output logic               rx_valid,
  output logic [MAX_LEN-1:0] rx_word
);
  logic [LEN_W-1:0]   len_eff, cnt_q;
  logic               sck_d, act, act_q, rise, last_edge;
  logic [MAX_LEN-1:0] sh_q, sh_nx, mask;

  always_comb begin
    if (frame_len < LEN_W'(MIN_LEN))      len_eff = LEN_W'(MIN_LEN);
    else if (frame_len > LEN_W'(MAX_LEN)) len_eff = LEN_W'(MAX_LEN);
    else                                  len_eff = frame_len;
  end

  assign act       = slave & (sel_s == sel_high);
  assign rise      = sck_s & ~sck_d;
  assign last_edge = act & rise & (cnt_q == len_eff - LEN_W'(1));
  assign sh_nx     = {sh_q[MAX_LEN-2:0], mosi_s};
  assign mask      = {MAX_LEN{1'b1}} >> (LEN_W'(MAX_LEN) - len_eff);

  // Release of select mid-frame
  assign mf_ev = slave & mf_en & act_q & ~act & (cnt_q != '0);
  // Frame end without room for a whole word
  assign ov_ev = last_edge & (rx_room < len_eff);

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d    <= 1'b0;
      act_q    <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      rx_valid <= 1'b0;
      rx_word  <= '0;
    end else begin
      sck_d    <= sck_s;
      act_q    <= act;
      rx_valid <= last_edge;
      if (!act) begin
        cnt_q <= '0;
      end else if (rise) begin
        sh_q  <= sh_nx;
        cnt_q <= last_edge ? '0 : cnt_q + LEN_W'(1);
      end
      if (last_edge) rx_word <= sh_nx & mask;
    end
  end
endmodule

// File: rtl/spi_err_flag.sv
module spi_err_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_ev,
  input  logic rd_hit,
  input  logic wr_hit,
  input  logic wr_bit,
  output logic flag
);
  logic armed;

  // Priority: new error, then armed clear, then arming read
  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else if (set_ev) begin
      flag  <= 1'b1;
      armed <= 1'b0;
    end else if (wr_hit && !wr_bit && armed) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else if (rd_hit && flag) begin
      armed <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_err_status.sv
module spi_err_status
  import spi_err_pkg::*;
#(
  parameter int MIN_LEN = 8,
  parameter int MAX_LEN = 32,
  parameter int LEN_W   = 6,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 4'h3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_slave,
  input  logic               cfg_mf_en,
  input  logic               cfg_sel_high,
  input  logic [LEN_W-1:0]   cfg_frame_len,
  input  logic [LEN_W-1:0]   rx_room,
  input  logic               spi_sck,
  input  logic               spi_sel,
  input  logic               spi_mosi,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               err_irq,
  output logic               rx_valid,
  output logic [MAX_LEN-1:0] rx_word
);
  localparam int SYNC_W = 3;

  logic [SYNC_W-1:0] pins_s;
  logic              mf_ev, ov_ev, rd_hit, wr_hit;
  logic [NFLAG-1:0]  set_ev, wbit, flag_q;
  logic              mf_flag, ov_flag;
  logic [DATA_W-1:0] stat;
  wire               unused_wdata = ^bus_wdata;

  spi_err_sync #(.W(SYNC_W), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_sck, spi_sel, spi_mosi}),
    .q   (pins_s)
  );

  spi_err_frame #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .slave     (cfg_slave),
    .mf_en     (cfg_mf_en),
    .sel_high  (cfg_sel_high),
    .frame_len (cfg_frame_len),
    .rx_room   (rx_room),
    .sck_s     (pins_s[2]),
    .sel_s     (pins_s[1]),
    .mosi_s    (pins_s[0]),
    .mf_ev     (mf_ev),
    .ov_ev     (ov_ev),
    .rx_valid  (rx_valid),
    .rx_word   (rx_word)
  );

  assign rd_hit = bus_rd & (bus_addr == STAT_ADDR);
  assign wr_hit = bus_wr & (bus_addr == STAT_ADDR);

  always_comb begin
    set_ev         = '0;
    wbit           = '0;
    set_ev[MF_IDX] = mf_ev;
    set_ev[OV_IDX] = ov_ev;
    wbit[MF_IDX]   = bus_wdata[MF_BIT];
    wbit[OV_IDX]   = bus_wdata[OV_BIT];
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    spi_err_flag u_flag (
      .clk    (clk),
      .rst    (rst),
      .set_ev (set_ev[g]),
      .rd_hit (rd_hit),
      .wr_hit (wr_hit),
      .wr_bit (wbit[g]),
      .flag   (flag_q[g])
    );
  end

  assign mf_flag = flag_q[MF_IDX];
  assign ov_flag = flag_q[OV_IDX];

  always_comb begin
    stat         = '0;
    stat[MF_BIT] = mf_flag;
    stat[OV_BIT] = ov_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      err_irq   <= 1'b0;
    end else begin
      bus_rdata <= rd_hit ? stat : '0;
      err_irq   <= |flag_q;
    end
  end
endmodule

// File: rtl/spi_err_status_chk.sv
module spi_err_status_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 4'h3
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_slave,
  input logic              cfg_mf_en,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wdata_mf,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              err_irq,
  input logic              rx_valid,
  input logic              mf_flag,
  input logic              ov_flag
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata[1] == 1'b0) && ((bus_rdata >> 3) == '0));

  assert_mf_needs_enable_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_mf_en) |-> !$rose(mf_flag));

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  assert_mf_clear_by_write_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(mf_flag) |-> $past(bus_wr && (bus_addr == STAT_ADDR) && !wdata_mf));

  assert_master_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_slave) |-> (!$rose(mf_flag) && !$rose(ov_flag)));

  assert_irq_follows_R13: assert property (@(posedge clk) disable iff (rst)
    err_irq == $past(mf_flag || ov_flag));
endmodule

bind spi_err_status spi_err_status_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_slave (cfg_slave),
  .cfg_mf_en (cfg_mf_en),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .wdata_mf  (bus_wdata[2]),
  .bus_rdata (bus_rdata),
  .err_irq   (err_irq),
  .rx_valid  (rx_valid),
  .mf_flag   (mf_flag),
  .ov_flag   (ov_flag)
);

// File: tb/spi_err_status_test.sv
module spi_err_status_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] STAT = 4'h3;

  logic clk = 0, rst = 1;
  logic cfg_slave = 1, cfg_mf_en = 0, cfg_sel_high = 0;
  logic [5:0] cfg_frame_len = 6'd8, rx_room = 6'd63;
  logic spi_sck = 0, spi_sel = 1, spi_mosi = 0;
  logic bus_rd = 0, bus_wr = 0;
  logic [3:0] bus_addr = STAT;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic err_irq, rx_valid;
  logic [31:0] rx_word;

  int n_chk = 0, n_fail = 0, n_valid = 0;
  logic [31:0] last_word = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_err_status uut (
    .clk(clk), .rst(rst), .cfg_slave(cfg_slave), .cfg_mf_en(cfg_mf_en),
    .cfg_sel_high(cfg_sel_high), .cfg_frame_len(cfg_frame_len), .rx_room(rx_room),
    .spi_sck(spi_sck), .spi_sel(spi_sel), .spi_mosi(spi_mosi),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .err_irq(err_irq), .rx_valid(rx_valid), .rx_word(rx_word)
  );

  // ---------------- behavioural reference model ----------------
  bit m_ck1, m_ck2, m_ckd, m_se1, m_se2, m_mo1, m_mo2, m_actd;
  int m_cnt;
  bit [63:0] m_sh;
  bit m_mf, m_ov, m_amf, m_aov, m_irq, m_valid;
  bit [7:0] m_rdata;
  bit [31:0] m_word;
  int len_i;
  bit act_i, rise_i, ev_mf, ev_ov, done_i, rdh, wrh;

  always @(posedge clk) begin
    if (rst) begin
      {m_ck1, m_ck2, m_ckd, m_se1, m_se2, m_mo1, m_mo2, m_actd} = '0;
      m_cnt = 0; m_sh = 0; m_mf = 0; m_ov = 0; m_amf = 0; m_aov = 0;
      m_irq = 0; m_valid = 0; m_rdata = 0; m_word = 0;
    end else begin
      len_i  = (cfg_frame_len < 8) ? 8 : (cfg_frame_len > 32) ? 32 : int'(cfg_frame_len);
      act_i  = cfg_slave && (m_se2 == cfg_sel_high);
      rise_i = m_ck2 && !m_ckd;
      ev_mf = 0; ev_ov = 0; done_i = 0;
      if (!act_i) begin
        if (cfg_slave && cfg_mf_en && m_actd && m_cnt != 0) ev_mf = 1;
        m_cnt = 0;
      end else if (rise_i) begin
        m_sh = {m_sh[62:0], m_mo2};
        m_cnt++;
        if (m_cnt == len_i) begin
          done_i = 1; m_cnt = 0;
          if (int'(rx_room) < len_i) ev_ov = 1;
          m_word = 32'(m_sh & ((64'h1 << len_i) - 1));
        end
      end
      rdh = bus_rd && bus_addr == STAT;
      wrh = bus_wr && bus_addr == STAT;
      m_rdata = rdh ? {5'b0, m_mf, 1'b0, m_ov} : 8'h00;
      m_irq   = m_mf || m_ov;
      m_valid = done_i;
      if (ev_mf) begin m_mf = 1; m_amf = 0; end
      else if (wrh && !bus_wdata[2] && m_amf) begin m_mf = 0; m_amf = 0; end
      else if (rdh && m_mf) m_amf = 1;
      if (ev_ov) begin m_ov = 1; m_aov = 0; end
      else if (wrh && !bus_wdata[0] && m_aov) begin m_ov = 0; m_aov = 0; end
      else if (rdh && m_ov) m_aov = 1;
      m_actd = act_i;
      m_ckd = m_ck2; m_ck2 = m_ck1; m_ck1 = spi_sck;
      m_se2 = m_se1; m_se1 = spi_sel;
      m_mo2 = m_mo1; m_mo1 = spi_mosi;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      chk("R2 rdata", 32'(bus_rdata), 32'(m_rdata));
      chk("R13 irq", 32'(err_irq), 32'(m_irq));
      chk("R7 valid", 32'(rx_valid), 32'(m_valid));
      chk("R7 word", rx_word, m_word);
      if (rx_valid) begin n_valid++; last_word = rx_word; end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask
  task automatic bit_out(input logic b);
    spi_mosi = b; spi_sck = 0; cyc(3); spi_sck = 1; cyc(3);
  endtask
  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
    spi_sck = 0; cyc(3);
  endtask
  task automatic sel_set(input logic active);
    spi_sel = active ? cfg_sel_high : ~cfg_sel_high; cyc(5);
  endtask
  task automatic rd(output logic [7:0] v);
    bus_addr = STAT; bus_rd = 1; cyc(1); bus_rd = 0; v = bus_rdata;
  endtask
  task automatic wr(input logic [7:0] d);
    bus_addr = STAT; bus_wdata = d; bus_wr = 1; cyc(1); bus_wr = 0;
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int nv;
    cyc(4); rst = 0; cyc(1);
    // R1 reset state
    chk("R1 rdata", 32'(bus_rdata), 0);
    chk("R1 irq", 32'(err_irq), 0);
    chk("R1 valid", 32'(rx_valid), 0);
    cyc(4);

    // R7 basic frame, R4 boundary release with no fault
    cfg_mf_en = 1;
    sel_set(1); send(32'hA5, 8); sel_set(0);
    chk("R7 word A5", last_word, 32'hA5);
    rd(v); chk("R4 no fault at boundary", 32'(v), 0);

    // R6 room equal to length: no overrun
    cfg_frame_len = 12; rx_room = 12;
    sel_set(1); send(32'hABC, 12); sel_set(0);
    rd(v); chk("R6 room equals length", 32'(v), 0);
    chk("R7 word 12 bits", last_word, 32'hABC);

    // R6 short room: overrun
    rx_room = 11;
    sel_set(1); send(32'h5A3, 12); sel_set(0);
    chk("R13 irq high", 32'(err_irq), 1);
    wr(8'h00); rd(v); chk("R8 write 0 without read keeps flag", 32'(v), 32'h01);
    wr(8'h01); rd(v); chk("R9 write 1 no effect", 32'(v), 32'h01);
    wr(8'hFE); rd(v); chk("R8 read then write 0 clears", 32'(v), 0);
    cyc(1); chk("R13 irq low", 32'(err_irq), 0);
    wr(8'hFF); rd(v); chk("R9 write ones on clear flags", 32'(v), 0);
    rx_room = 63;

    // R3 mode fault mid-frame
    sel_set(1); send(32'h15, 5); sel_set(0);
    rd(v); chk("R3 mode fault set", 32'(v), 32'h04);
    wr(8'h00); rd(v); chk("R8 mode fault cleared", 32'(v), 0);

    // R4 enable off
    cfg_mf_en = 0;
    sel_set(1); send(32'h3, 3); sel_set(0);
    rd(v); chk("R4 disabled no fault", 32'(v), 0);
    cfg_mf_en = 1;

    // R5 active-high select
    spi_sel = 0; cfg_sel_high = 1; cyc(5);
    nv = n_valid;
    send(32'hFF, 12);
    chk("R5 inactive no word", 32'(n_valid), 32'(nv));
    rd(v); chk("R5 inactive no flag", 32'(v), 0);
    sel_set(1); send(32'h5, 3); sel_set(0);
    rd(v); chk("R5 active-high fault", 32'(v), 32'h04);

    // R11 new event between read and write cancels clear
    sel_set(1); send(32'h2, 2); sel_set(0);
    wr(8'h00); rd(v); chk("R11 fresh error kept", 32'(v), 32'h04);
    wr(8'h00); rd(v); chk("R11 cleared after rearm", 32'(v), 0);

    // R12 set and clear in the same cycle
    sel_set(1); send(32'h1, 2); sel_set(0);
    rd(v);
    sel_set(1); send(32'h1, 2);
    spi_sel = 0; cyc(2);
    bus_addr = STAT; bus_wdata = 8'h00; bus_wr = 1; cyc(1); bus_wr = 0; cyc(3);
    rd(v); chk("R12 set wins", 32'(v), 32'h04);
    rd(v); wr(8'h00); rd(v); chk("R12 cleanup", 32'(v), 0);

    // R10 master mode
    cfg_slave = 0; rx_room = 0;
    nv = n_valid;
    sel_set(1); send(32'hFFF, 12); send(32'h5, 3); sel_set(0);
    rd(v); chk("R10 master no flags", 32'(v), 0);
    chk("R10 master no word", 32'(n_valid), 32'(nv));
    cfg_slave = 1; rx_room = 63;

    // R7 length clamps
    cfg_sel_high = 0; spi_sel = 1; cyc(5);
    cfg_frame_len = 3;
    sel_set(1); send(32'h3C, 8); sel_set(0);
    chk("R7 clamp low to 8", last_word, 32'h3C);
    cfg_frame_len = 40;
    sel_set(1); send(32'hDEADBEEF, 32); sel_set(0);
    chk("R7 clamp high to 32", last_word, 32'hDEADBEEF);
    rd(v); chk("R7 no flags after full frames", 32'(v), 0);

    cyc(5);
    finish_run();
  end
endmodule